// File: doc/BRIEF.md
# Parallel multi-length PRBS word generator

The block delivers one 16-bit slice of a pseudorandom bit sequence on every enabled clock. Each slice is sixteen consecutive bits of the serial sequence, with bit 0 the earliest bit in serial order. A serial shift register followed by a 1:16 demultiplexer would give the same words, but this block runs at the word rate. All sixteen new bits come from XOR logic applied to the words already held. For the short sequences the logic also uses the bits it produces earlier in the same word, so one stored word is enough. For the long sequences the taps reach back two words.

A 3-bit select picks one of five sequence lengths. The datapath keeps two 18-bit word registers as a two-deep chain. Each register holds 16 sequence bits and the two serial bits that come just before them. The two bits in front of the current word are brought out for downstream logic. After reset, and after any change of the selected length, both registers are preset to all ones, so the history is never all zero. The valid flag then stays low until the history holds only generated bits.

Top module: `prbs_word_gen`

## Requirements
- R1: Each word bit follows the serial recurrence b[k] = b[k-n] ^ b[k-m] for the selected (n, m). Successive words are contiguous in serial order, and word bit 0 is the earliest bit. The serial history before the first generated bit is all ones.
- R2: Select codes 0, 1, 2, 3 and 4 give (n, m) = (7, 6), (10, 7), (15, 14), (23, 18) and (31, 28). Codes 5 to 7 behave as code 0, so moving between code 0 and code 5, 6 or 7 does not reseed the generator.
- R3: While reset is asserted, the generator is seeded at the clock: `word` reads 16'hFFFF, `tail_bits` reads 2'b11 and `valid` is low.
- R4: A change of the decoded select reseeds the registers at the next clock and drops `valid`. After that, `valid` returns after one enabled advance for n of 15 or less, and after two enabled advances for n of 23 or 31.
- R5: While `en` is low and no reseed occurs, `word`, `tail_bits` and `valid` hold their values.
- R6: `tail_bits[1]` is the serial bit just before word bit 0, and `tail_bits[0]` is the bit before that.
- R7: The stored two-word history is never all zero outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance by one word |
| len_sel | input | 3 | Sequence length code |
| word | output | 16 | Current pseudorandom word, bit 0 earliest |
| tail_bits | output | 2 | The two serial bits before word bit 0 |
| valid | output | 1 | Word contains only generated bits |

## Verification
The bench builds the block with its default parameters: a 16-bit word, 2 extension bits and five lengths. With these values both paths are covered. The 7-, 10- and 15-bit lengths need the in-word expansion, and the 23- and 31-bit lengths need the two-word taps. The 7- and 10-bit runs go past a full period of 127 and 1023 words, so the wrap of the sequence is compared bit for bit against a serial reference. The enable is dropped at random, and length changes and fallback codes are applied mid-run, to exercise reseeding and refill timing.

// File: rtl/prbs_word_pkg.sv
package prbs_word_pkg;
  localparam int NUM_LEN = 5;
  localparam int SEL_W = 3;

  // Long tap (sequence degree) for each length code.
  function automatic int poly_n(int idx);
    case (idx)
      1: return 10;
      2: return 15;
      3: return 23;
      4: return 31;
      default: return 7;
    endcase
  endfunction

  // Short tap for each length code.
  function automatic int poly_m(int idx);
    case (idx)
      1: return 7;
      2: return 14;
      3: return 18;
      4: return 28;
      default: return 6;
    endcase
  endfunction
endpackage

// File: rtl/prbs_word_step.sv
module prbs_word_step #(
  parameter int WORD_W = 16,
  parameter int EXT_W  = 2,
  parameter int TAP_N  = 7,
  parameter int TAP_M  = 6
) (
  input  logic [2*WORD_W+EXT_W-1:0] hist,
  output logic [WORD_W-1:0]         nxt
);
  localparam int HW = 2*WORD_W + EXT_W;

  // hist[0] is the earliest serial bit. New bit i sits at index HW+i.
  // A new bit may depend on bits that were produced earlier in the same word.
  function automatic logic [WORD_W-1:0] expand(logic [HW-1:0] h);
    logic [HW+WORD_W-1:0] s;
    s = {{WORD_W{1'b0}}, h};
    for (int i = 0; i < WORD_W; i++) begin
      s[HW+i] = s[HW+i-TAP_N] ^ s[HW+i-TAP_M];
    end
    return s[HW+WORD_W-1:HW];
  endfunction

  assign nxt = expand(hist);
endmodule

// File: rtl/prbs_len_ctrl.sv
module prbs_len_ctrl
  import prbs_word_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SEL_W-1:0] len_sel,
  output logic [SEL_W-1:0] sel_q,
  output logic             reseed,
  output logic             valid
);
  logic [SEL_W-1:0] sel_dec;
  logic [1:0]       fill_q;
  logic             need_two;

  assign sel_dec  = (len_sel < SEL_W'(NUM_LEN)) ? len_sel : '0;
  assign reseed   = rst | (sel_dec != sel_q);
  assign need_two = poly_n(int'(sel_q)) > WORD_W;
  assign valid    = need_two ? (fill_q == 2'd2) : (fill_q != 2'd0);

  always_ff @(posedge clk) begin
    sel_q <= sel_dec;
    if (reseed) fill_q <= 2'd0;
    else if (en && fill_q != 2'd2) fill_q <= fill_q + 2'd1;
  end

  // R4: a length change always yields an invalid word on the next cycle
  assert_change_drops_R4: assert property (@(posedge clk) disable iff (rst)
    (sel_dec != sel_q) |=> !valid);

  // R4: a short length refills after one advance
  assert_short_refill_R4: assert property (@(posedge clk) disable iff (rst)
    (fill_q == 2'd0 && en && !reseed && !need_two) |=> valid);

  // R4: a long length is still invalid after one advance
  assert_long_refill_R4: assert property (@(posedge clk) disable iff (rst)
    (fill_q == 2'd0 && en && !reseed && need_two) |=> !valid);
endmodule

// File: rtl/prbs_word_gen.sv
module prbs_word_gen
  import prbs_word_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int EXT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [SEL_W-1:0]  len_sel,
  output logic [WORD_W-1:0] word,
  output logic [EXT_W-1:0]  tail_bits,
  output logic              valid
);
  localparam int REG_W = WORD_W + EXT_W;
  localparam int HW    = 2*WORD_W + EXT_W;

  // Register layout: [WORD_W-1:0] holds the word, and the upper EXT_W bits hold
  // the serial bits just before word bit 0, in ascending serial order.
  logic [REG_W-1:0] cur_q, prev_q;
  logic [HW-1:0]    hist;
  logic [WORD_W-1:0] cand [NUM_LEN];
  logic [WORD_W-1:0] nxt_word;
  logic [SEL_W-1:0]  sel_q;
  logic              reseed;

  prbs_len_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rst(rst), .en(en), .len_sel(len_sel),
    .sel_q(sel_q), .reseed(reseed), .valid(valid)
  );

  assign hist = {cur_q[WORD_W-1:0], prev_q[WORD_W-1:0], prev_q[REG_W-1:WORD_W]};

  for (genvar g = 0; g < NUM_LEN; g++) begin : g_len
    prbs_word_step #(
      .WORD_W(WORD_W), .EXT_W(EXT_W),
      .TAP_N(poly_n(g)), .TAP_M(poly_m(g))
    ) u_step (
      .hist(hist), .nxt(cand[g])
    );
  end

  assign nxt_word = cand[sel_q];

  always_ff @(posedge clk) begin
    if (reseed) begin
      cur_q  <= '1;
      prev_q <= '1;
    end else if (en) begin
      prev_q <= cur_q;
      cur_q  <= {cur_q[WORD_W-1:WORD_W-EXT_W], nxt_word};
    end
  end

  assign word      = cur_q[WORD_W-1:0];
  assign tail_bits = cur_q[REG_W-1:WORD_W];

  // R7: the two-word history never collapses to zero
  assert_hist_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
    hist != '0);

  // R5: a word is held while disabled
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!en && !reseed) |=> ($stable(word) && $stable(tail_bits)));
endmodule

// File: tb/prbs_word_gen_tb.sv
`timescale 1ns/1ps
module prbs_word_gen_tb;
  logic clk = 1'b0;
  logic rst, en;
  logic [2:0] len_sel;
  logic [15:0] word;
  logic [1:0] tail_bits;
  logic valid;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // Reference model state
  logic [63:0] rh;          // rh[0] is the most recent serial bit
  logic [15:0] exp_word;
  int          fill;
  int          model_sel;
  logic        exp_valid;
  logic [15:0] last_word;

  always #2.5 clk = ~clk;

  prbs_word_gen u_dut (
    .clk(clk), .rst(rst), .en(en), .len_sel(len_sel),
    .word(word), .tail_bits(tail_bits), .valid(valid)
  );

  function automatic int ref_n(int c);
    case (c) 1: return 10; 2: return 15; 3: return 23; 4: return 31; default: return 7; endcase
  endfunction
  function automatic int ref_m(int c);
    case (c) 1: return 7; 2: return 14; 3: return 18; 4: return 28; default: return 6; endcase
  endfunction
  function automatic int decode(int code);
    return (code > 4) ? 0 : code;
  endfunction

  task automatic ref_seed();
    rh = '1; exp_word = 16'hFFFF; fill = 0;
  endtask

  task automatic ref_advance();
    int n, m;
    logic b;
    n = ref_n(model_sel); m = ref_m(model_sel);
    for (int i = 0; i < 16; i++) begin
      b = rh[n-1] ^ rh[m-1];
      rh = {rh[62:0], b};
      exp_word[i] = b;
    end
    if (fill < 2) fill++;
  endtask

  task automatic check(string tag);
    int need;
    need = (ref_n(model_sel) > 16) ? 2 : 1;
    exp_valid = (fill >= need);
    vectors++;
    if (word !== exp_word) begin
      fails++; $display("FAIL %s word actual=%h expected=%h", tag, word, exp_word);
    end
    if (tail_bits !== {rh[16], rh[17]}) begin
      fails++; $display("FAIL %s tail_bits actual=%b expected=%b", (tag == "R1") ? "R6" : tag,
                        tail_bits, {rh[16], rh[17]});
    end
    if (valid !== exp_valid) begin
      fails++; $display("FAIL %s valid actual=%b expected=%b", (tag == "R1") ? "R4" : tag,
                        valid, exp_valid);
    end
    if (ref_n(model_sel) > 16 && valid && word == 16'h0 && last_word == 16'h0) begin
      fails++; $display("FAIL R7 history actual=0 expected=nonzero");
    end
    last_word = word;
  endtask

  // One clock: drive at negedge, model the edge, sample 1 ns after it.
  task automatic step(logic e, int code, string tag);
    @(negedge clk);
    en = e; len_sel = 3'(code);
    @(posedge clk);
    #1;
    if (decode(code) != model_sel) begin
      model_sel = decode(code);
      ref_seed();
    end else if (e) begin
      ref_advance();
    end
    check(e ? tag : "R5");
  endtask

  task automatic run_len(int code, int words, bit random_en);
    int adv = 0;
    while (adv < words) begin
      logic e;
      e = random_en ? (($urandom % 4) != 0) : 1'b1;
      step(e, code, "R1");
      if (e) adv++;
    end
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    rst = 1'b1; en = 1'b0; len_sel = 3'd0; last_word = 16'hFFFF;
    model_sel = 0; ref_seed();
    repeat (3) @(posedge clk);
    #1;
    check("R3");
    if (word !== 16'hFFFF || tail_bits !== 2'b11) begin
      fails++; $display("FAIL R3 seed actual=%h/%b expected=ffff/11", word, tail_bits);
    end
    vectors++;
    @(negedge clk); rst = 1'b0;

    run_len(0, 300, 1);             // R1 n=7 beyond two periods
    step(1'b1, 6, "R2");            // R2 code 6 falls back, no reseed
    step(1'b1, 5, "R2");
    run_len(7, 20, 0);              // R2 code 7 continues length 7
    step(1'b1, 1, "R4");            // R4 reseed into n=10
    run_len(1, 1100, 1);            // R1 n=10 over a full period
    step(1'b0, 2, "R4");            // R4 reseed while disabled
    step(1'b0, 2, "R5");
    run_len(2, 200, 1);             // R1 n=15
    step(1'b1, 3, "R4");            // R4 long refill takes two advances
    step(1'b1, 3, "R4");
    run_len(3, 200, 1);             // R1 n=23
    step(1'b1, 4, "R4");
    run_len(4, 200, 1);             // R1 n=31
    step(1'b1, 5, "R2");            // R2 code 5 reseeds to length 7
    run_len(5, 50, 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule